// File: doc/BRIEF.md
# PTP System Time Counter

This block holds a precision-time-protocol system clock as two 32-bit quantities: a seconds count and a sub-second count. While counting is enabled, the sub-second count grows by a programmable 8-bit step. In coarse mode the step is applied on every clock. In fine mode the step is applied only when a 32-bit phase accumulator, which adds a programmable addend on every clock, carries out. Software sets the effective rate by trimming the addend. The sub-second count wraps into the seconds count. The wrap point is either one billion, for nanosecond counting, or 2^31, for binary fractions of about 0.466 ns per count.

Software drives the block through a small 32-bit register bus. It can load an absolute time, or shift the running time by a signed amount with a single command. To shift backward, software writes the two's complement of the seconds and the sub-second complement with respect to the wrap value, and sets a subtract flag. The block then performs one modular addition and borrows from the seconds. Commands are one-shot bits that clear themselves once they have acted. A read of the sub-second count captures the seconds value of the same instant, so that a seconds read that follows returns a consistent pair.

Register offsets are as follows. 0x00 is control. 0x04 is the step. 0x08 is seconds and 0x0C is sub-seconds, both read-only. 0x10 is the seconds adjust value. 0x14 is the sub-second adjust value, with its subtract flag at bit 31. 0x18 is the addend.

Top module: `ptp_sys_clock`

## Requirements
- R1: After reset, every register (control, step, seconds, sub-seconds, both adjust registers and addend) reads as zero.
- R2: Control keeps bit 0 (count enable), bit 1 (1 = fine, 0 = coarse) and bit 9 (1 = decimal wrap) and reads other unused bits as 0. The step sits in bits 7:0 of 0x04, or in bits 23:16 when the high-field variant is selected, and the other bits read 0. Both adjust registers read back exactly as written.
- R3: While control bit 0 is 0, the seconds and sub-second counts hold their values.
- R4: In coarse mode the sub-second count grows by the step on each clock edge after the edge that writes enable = 1, up to and including the edge that writes enable = 0.
- R5: With decimal wrap, a sub-second sum at or above 1,000,000,000 has that value subtracted and adds one to seconds.
- R6: With binary wrap, the sub-second count wraps at 0x80000000 and adds one to seconds. Sums between one billion and 2^31 do not wrap.
- R7: In fine mode a 32-bit accumulator adds the active addend on every enabled clock, and the step is applied only on a carry out of bit 31.
- R8: A write to 0x18 stages the addend only. Offset 0x18 reads the active addend, which takes the staged value one edge after control bit 5 is written as 1.
- R9: Writing control bit 2 loads seconds from 0x10 and sub-seconds from bits 30:0 of 0x14. Bit 31 of 0x14 is not loaded.
- R10: Writing control bit 3 with bit 31 of 0x14 clear adds bits 30:0 of 0x14 to sub-seconds with wrap, and adds 0x10 plus the wrap carry to seconds.
- R11: With bit 31 of 0x14 set, the same step command adds both values, but subtracts one from seconds when the sub-second sum does not wrap.
- R12: Command bits 2, 3 and 5 act on the edge after the write and then read back as 0.
- R13: A control write that lands on the edge while a command is still pending has its command bits ignored. Its mode bits still take effect.
- R14: A read of 0x0C captures seconds. The next read, if it is of 0x08, returns that captured value. A read of 0x08 that does not directly follow a 0x0C read returns the live seconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; rdata updates on the same edge |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, held between reads |

## Verification
A wrong carry, a wrong wrap constant or a wrong borrow is visible at the ports. Each appears at the first sub-second or seconds read after a single step or adjust command, because every test parks the clock in a known state and reads it back with counting disabled. A wrong accumulator or a misplaced enable window changes the number of steps applied. That shows up as an exact multiple of the step in the sub-second value after a known count of enabled edges. A command bit that sticks or is not dropped shows up in the next control read, or as a double adjustment of the time.

// File: rtl/ptp_clk_pkg.sv
package ptp_clk_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] REG_CTRL  = 5'h00;
    localparam logic [ADDR_W-1:0] REG_STEP  = 5'h04;
    localparam logic [ADDR_W-1:0] REG_SEC   = 5'h08;
    localparam logic [ADDR_W-1:0] REG_SUB   = 5'h0C;
    localparam logic [ADDR_W-1:0] REG_ASEC  = 5'h10;
    localparam logic [ADDR_W-1:0] REG_ASUB  = 5'h14;
    localparam logic [ADDR_W-1:0] REG_ADDND = 5'h18;

    localparam int CB_EN   = 0;
    localparam int CB_FINE = 1;
    localparam int CB_INIT = 2;
    localparam int CB_STEP = 3;
    localparam int CB_ALD  = 5;
    localparam int CB_DEC  = 9;

    localparam logic [DATA_W-1:0] WRAP_DEC = 32'd1_000_000_000;
    localparam logic [DATA_W-1:0] WRAP_BIN = 32'h8000_0000;

    typedef struct packed {
        logic en;
        logic fine;
        logic dec;
    } mode_t;

    typedef struct packed {
        logic init;
        logic step;
        logic addld;
    } cmd_t;

    typedef struct packed {
        logic [DATA_W-1:0] sec;
        logic [DATA_W-1:0] sub;
    } systime_t;

    typedef struct packed {
        logic              wrapped;
        logic [DATA_W-1:0] val;
    } wrap_t;

    function automatic logic [DATA_W-1:0] wrap_of(input logic dec);
        return dec ? WRAP_DEC : WRAP_BIN;
    endfunction

    // Modular add of a sub-second amount; reports whether the limit was crossed.
    function automatic wrap_t wrap_add(input logic [DATA_W-1:0] base,
                                       input logic [DATA_W-1:0] amt,
                                       input logic [DATA_W-1:0] lim);
        wrap_t      r;
        logic [DATA_W:0] s;
        logic [DATA_W:0] d;
        s = {1'b0, base} + {1'b0, amt};
        d = s - {1'b0, lim};
        r.wrapped = (s >= {1'b0, lim});
        r.val     = r.wrapped ? d[DATA_W-1:0] : s[DATA_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/ptp_csr_bank.sv
module ptp_csr_bank
    import ptp_clk_pkg::*;
#(
    parameter int INC_W     = 8,
    parameter bit INC_AT_HI = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output mode_t             mode,
    output cmd_t              cmd,
    output logic [INC_W-1:0]  inc,
    output logic [DATA_W-1:0] adj_sec,
    output logic [DATA_W-2:0] adj_sub,
    output logic              adj_neg,
    output logic [DATA_W-1:0] addend,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [DATA_W-1:0] inc_rd
);

    localparam int HI_LSB = 16;

    logic [INC_W-1:0]  inc_wr;
    logic [DATA_W-1:0] addend_stage;
    logic              unused_wbits;

    assign unused_wbits = ^wdata;

    generate
        if (INC_AT_HI) begin : g_inc_hi
            assign inc_wr = wdata[HI_LSB +: INC_W];
            assign inc_rd = {{(DATA_W-HI_LSB-INC_W){1'b0}}, inc, {HI_LSB{1'b0}}};
        end else begin : g_inc_lo
            assign inc_wr = wdata[0 +: INC_W];
            assign inc_rd = {{(DATA_W-INC_W){1'b0}}, inc};
        end
    endgenerate

    logic wr_ctrl;
    logic wr_step;
    logic wr_asec;
    logic wr_asub;
    logic wr_addnd;

    assign wr_ctrl  = wr_en && (addr == REG_CTRL);
    assign wr_step  = wr_en && (addr == REG_STEP);
    assign wr_asec  = wr_en && (addr == REG_ASEC);
    assign wr_asub  = wr_en && (addr == REG_ASUB);
    assign wr_addnd = wr_en && (addr == REG_ADDND);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode         <= '0;
            cmd          <= '0;
            inc          <= '0;
            adj_sec      <= '0;
            adj_sub      <= '0;
            adj_neg      <= 1'b0;
            addend       <= '0;
            addend_stage <= '0;
        end else begin
            if (wr_ctrl) begin
                mode.en   <= wdata[CB_EN];
                mode.fine <= wdata[CB_FINE];
                mode.dec  <= wdata[CB_DEC];
            end
            // one-shot commands: a pending one blocks new ones
            if (cmd != '0) begin
                cmd <= '0;
            end else if (wr_ctrl) begin
                cmd.init  <= wdata[CB_INIT];
                cmd.step  <= wdata[CB_STEP];
                cmd.addld <= wdata[CB_ALD];
            end
            if (wr_step)  inc          <= inc_wr;
            if (wr_asec)  adj_sec      <= wdata;
            if (wr_asub) begin
                adj_sub <= wdata[DATA_W-2:0];
                adj_neg <= wdata[DATA_W-1];
            end
            if (wr_addnd) addend_stage <= wdata;
            if (cmd.addld) addend      <= addend_stage;
        end
    end

    always_comb begin
        ctrl_rd          = '0;
        ctrl_rd[CB_EN]   = mode.en;
        ctrl_rd[CB_FINE] = mode.fine;
        ctrl_rd[CB_DEC]  = mode.dec;
        ctrl_rd[CB_INIT] = cmd.init;
        ctrl_rd[CB_STEP] = cmd.step;
        ctrl_rd[CB_ALD]  = cmd.addld;
    end

    // R12/R13: a pending command lives exactly one cycle
    assert_cmd_one_shot_R12: assert property (@(posedge clk) disable iff (rst)
        (cmd != '0) |=> (cmd == '0));

    // R8: active addend moves only on a load command
    assert_addend_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !cmd.addld |=> $stable(addend));

endmodule

// File: rtl/ptp_tick_gen.sv
module ptp_tick_gen
    import ptp_clk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              fine,
    input  logic [DATA_W-1:0] addend,
    output logic              tick
);

    logic [DATA_W-1:0] acc_q;
    logic [DATA_W:0]   acc_sum;

    assign acc_sum = {1'b0, acc_q} + {1'b0, addend};
    assign tick    = run && (fine ? acc_sum[DATA_W] : 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (run && fine) begin
            acc_q <= acc_sum[DATA_W-1:0];
        end
    end

    // R7: an addend below half scale never carries on two edges in a row
    assert_fine_spacing_R7: assert property (@(posedge clk) disable iff (rst)
        (run && fine && tick && !addend[DATA_W-1])
        |=> !(run && fine && tick && $stable(addend)));

endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core
    import ptp_clk_pkg::*;
#(
    parameter int INC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              dec,
    input  logic [INC_W-1:0]  inc,
    input  logic              do_init,
    input  logic              do_step,
    input  logic [DATA_W-1:0] adj_sec,
    input  logic [DATA_W-2:0] adj_sub,
    input  logic              adj_neg,
    output systime_t          now
);

    logic [DATA_W-1:0] lim;
    wrap_t             adv;
    wrap_t             shf;
    logic [DATA_W-1:0] sec_fix;

    assign lim = wrap_of(dec);
    assign adv = wrap_add(now.sub, {{(DATA_W-INC_W){1'b0}}, inc}, lim);
    assign shf = wrap_add(now.sub, {1'b0, adj_sub}, lim);

    always_comb begin
        if (adj_neg)
            sec_fix = shf.wrapped ? '0 : '1;
        else
            sec_fix = shf.wrapped ? {{(DATA_W-1){1'b0}}, 1'b1} : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now <= '0;
        end else if (do_init) begin
            now.sec <= adj_sec;
            now.sub <= {1'b0, adj_sub};
        end else if (do_step) begin
            now.sec <= now.sec + adj_sec + sec_fix;
            now.sub <= shf.val;
        end else if (en && tick) begin
            now.sec <= now.sec + {{(DATA_W-1){1'b0}}, adv.wrapped};
            now.sub <= adv.val;
        end
    end

    // R3: counting disabled and no command -> time frozen
    assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (rst)
        (!en && !do_init && !do_step) |=> ($stable(now.sec) && $stable(now.sub)));

    // R5: decimal counting keeps an in-range value in range
    assert_dec_range_R5: assert property (@(posedge clk) disable iff (rst)
        (dec && !do_init && !do_step && (now.sub < WRAP_DEC)) |=> (now.sub < WRAP_DEC));

    // R6: binary counting keeps an in-range value in range
    assert_bin_range_R6: assert property (@(posedge clk) disable iff (rst)
        (!dec && !do_init && !do_step && (now.sub < WRAP_BIN)) |=> (now.sub < WRAP_BIN));

endmodule

// File: rtl/ptp_sys_clock.sv
module ptp_sys_clock
    import ptp_clk_pkg::*;
#(
    parameter int INC_W     = 8,
    parameter bit INC_AT_HI = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    mode_t             mode;
    cmd_t              cmd;
    logic [INC_W-1:0]  inc;
    logic [DATA_W-1:0] adj_sec;
    logic [DATA_W-2:0] adj_sub;
    logic              adj_neg;
    logic [DATA_W-1:0] addend;
    logic [DATA_W-1:0] ctrl_rd;
    logic [DATA_W-1:0] inc_rd;
    logic              tick;
    systime_t          now;
    logic [DATA_W-1:0] snap_sec;
    logic              snap_ok;
    logic [DATA_W-1:0] rd_mux;

    ptp_csr_bank #(.INC_W(INC_W), .INC_AT_HI(INC_AT_HI)) u_csr (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .mode(mode), .cmd(cmd), .inc(inc), .adj_sec(adj_sec), .adj_sub(adj_sub),
        .adj_neg(adj_neg), .addend(addend), .ctrl_rd(ctrl_rd), .inc_rd(inc_rd)
    );

    ptp_tick_gen u_tick (
        .clk(clk), .rst(rst), .run(mode.en), .fine(mode.fine),
        .addend(addend), .tick(tick)
    );

    ptp_time_core #(.INC_W(INC_W)) u_core (
        .clk(clk), .rst(rst), .en(mode.en), .tick(tick), .dec(mode.dec),
        .inc(inc), .do_init(cmd.init), .do_step(cmd.step),
        .adj_sec(adj_sec), .adj_sub(adj_sub), .adj_neg(adj_neg), .now(now)
    );

    always_comb begin
        unique case (addr)
            REG_CTRL:  rd_mux = ctrl_rd;
            REG_STEP:  rd_mux = inc_rd;
            REG_SEC:   rd_mux = snap_ok ? snap_sec : now.sec;
            REG_SUB:   rd_mux = now.sub;
            REG_ASEC:  rd_mux = adj_sec;
            REG_ASUB:  rd_mux = {adj_neg, adj_sub};
            REG_ADDND: rd_mux = addend;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata    <= '0;
            snap_sec <= '0;
            snap_ok  <= 1'b0;
        end else if (rd_en) begin
            rdata   <= rd_mux;
            snap_ok <= (addr == REG_SUB);
            if (addr == REG_SUB) snap_sec <= now.sec;
        end
    end

    // R14: a sub-second read captures the seconds of the same edge
    assert_snapshot_R14: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == REG_SUB) |=> (snap_ok && snap_sec == $past(now.sec)));

    // R2: read data only changes on a read
    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

// File: tb/ptp_sys_clock_test.sv
module ptp_sys_clock_test;

    localparam logic [4:0] A_CTRL = 5'h00, A_STEP = 5'h04, A_SEC = 5'h08, A_SUB = 5'h0C,
                           A_ASEC = 5'h10, A_ASUB = 5'h14, A_ADD = 5'h18;
    localparam logic [31:0] EN = 32'h1, FINE = 32'h2, INIT = 32'h4, STEP = 32'h8,
                            ALD = 32'h20, DEC = 32'h200, NEG = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ptp_sys_clock #(.INC_W(8), .INC_AT_HI(1'b0)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic read_time(output logic [31:0] s, output logic [31:0] ss);
        rd(A_SUB, ss);
        rd(A_SEC, s);
    endtask

    task automatic set_time(input logic [31:0] s, input logic [31:0] ss, input logic [31:0] md);
        wr(A_ASEC, s);
        wr(A_ASUB, ss);
        wr(A_CTRL, md | INIT);
    endtask

    // enabled for m+2 clock edges, then disabled
    task automatic run_for(input int m, input logic [31:0] md);
        wr(A_CTRL, md | EN);
        repeat (m) @(negedge clk);
        wr(A_CTRL, md);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_CTRL, v);  check("R1 ctrl", v, 0);
        rd(A_STEP, v);  check("R1 step", v, 0);
        rd(A_SEC, v);   check("R1 sec", v, 0);
        rd(A_SUB, v);   check("R1 sub", v, 0);
        rd(A_ASEC, v);  check("R1 adj sec", v, 0);
        rd(A_ASUB, v);  check("R1 adj sub", v, 0);
        rd(A_ADD, v);   check("R1 addend", v, 0);
    endtask

    task automatic t_fields;
        logic [31:0] v;
        wr(A_STEP, 32'hAB00_0012);
        rd(A_STEP, v);  check("R2 step field", v, 32'h12);
        wr(A_ASUB, 32'h8000_0005);
        rd(A_ASUB, v);  check("R2 adj sub readback", v, 32'h8000_0005);
        wr(A_CTRL, 32'h212);
        rd(A_CTRL, v);  check("R2 ctrl mode bits", v, 32'h202);
        wr(A_CTRL, 0);
    endtask

    task automatic t_addend;
        logic [31:0] v;
        wr(A_ADD, 32'h8000_0000);
        rd(A_ADD, v);   check("R8 staged only", v, 0);
        wr(A_CTRL, ALD);
        rd(A_CTRL, v);  check("R12 load bit cleared", v, 0);
        rd(A_ADD, v);   check("R8 loaded", v, 32'h8000_0000);
    endtask

    task automatic t_init_hold;
        logic [31:0] s, ss;
        wr(A_STEP, 10);
        set_time(5, NEG | 32'd100, DEC);
        repeat (10) @(negedge clk);
        read_time(s, ss);
        check("R9 init sub ignores flag", ss, 100);
        check("R3 sec held while disabled", s, 5);
        rd(A_CTRL, s);  check("R12 init bit cleared", s, DEC);
    endtask

    task automatic t_ignore;
        logic [31:0] s, ss;
        wr(A_ASEC, 50);
        wr(A_ASUB, 20);
        @(negedge clk);
        wr_en = 1'b1; addr = A_CTRL; wdata = DEC | INIT;
        @(negedge clk);
        wdata = DEC | STEP;
        @(negedge clk);
        wr_en = 1'b0;
        read_time(s, ss);
        check("R13 step ignored sec", s, 50);
        check("R13 step ignored sub", ss, 20);
    endtask

    task automatic t_coarse;
        logic [31:0] s, ss;
        set_time(0, 0, DEC);
        wr(A_STEP, 10);
        run_for(8, DEC);
        read_time(s, ss);
        check("R4 coarse 10 edges", ss, 100);
        check("R4 coarse sec", s, 0);
    endtask

    task automatic t_dec_wrap;
        logic [31:0] s, ss;
        set_time(7, 999_999_990, DEC);
        run_for(0, DEC);
        read_time(s, ss);
        check("R5 decimal wrap sub", ss, 10);
        check("R5 decimal carry sec", s, 8);
    endtask

    task automatic t_bin_wrap;
        logic [31:0] s, ss;
        set_time(7, 999_999_990, 0);
        run_for(0, 0);
        read_time(s, ss);
        check("R6 binary no wrap at 1e9", ss, 32'd1_000_000_010);
        check("R6 binary no carry", s, 7);
        set_time(7, 32'h7FFF_FFF0, 0);
        wr(A_STEP, 32'h20);
        run_for(0, 0);
        read_time(s, ss);
        check("R6 binary wrap sub", ss, 32'h30);
        check("R6 binary carry sec", s, 8);
    endtask

    task automatic t_fine;
        logic [31:0] s, ss;
        set_time(0, 0, DEC);
        wr(A_STEP, 10);
        run_for(8, FINE | DEC);
        read_time(s, ss);
        check("R7 fine half-scale addend", ss, 50);
        wr(A_ADD, 32'h4000_0000);
        wr(A_CTRL, ALD | DEC);
        set_time(0, 0, DEC);
        run_for(6, FINE | DEC);
        read_time(s, ss);
        check("R7 fine quarter-scale addend", ss, 20);
    endtask

    task automatic t_adjust;
        logic [31:0] s, ss;
        set_time(100, 500_000_000, DEC);
        wr(A_ASEC, 3);
        wr(A_ASUB, 600_000_000);
        wr(A_CTRL, DEC | STEP);
        read_time(s, ss);
        check("R10 add sub", ss, 100_000_000);
        check("R10 add sec with carry", s, 104);
        rd(A_CTRL, s);  check("R12 step bit cleared", s, DEC);
        wr(A_ASEC, 32'hFFFF_FFFE);
        wr(A_ASUB, NEG | 32'd700_000_000);
        wr(A_CTRL, DEC | STEP);
        read_time(s, ss);
        check("R11 subtract sub", ss, 800_000_000);
        check("R11 subtract sec with borrow", s, 101);
        wr(A_ASEC, 0);
        wr(A_ASUB, NEG | 32'd900_000_000);
        wr(A_CTRL, DEC | STEP);
        read_time(s, ss);
        check("R11 subtract sub no borrow", ss, 700_000_000);
        check("R11 subtract sec no borrow", s, 101);
    endtask

    task automatic t_snapshot;
        logic [31:0] v;
        rd(A_SUB, v);
        set_time(555, 7, DEC);
        rd(A_SEC, v);   check("R14 captured seconds", v, 101);
        rd(A_SEC, v);   check("R14 live seconds", v, 555);
        rd(A_SUB, v);   check("R14 live sub", v, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_fields;
        t_addend;
        t_init_hold;
        t_ignore;
        t_coarse;
        t_dec_wrap;
        t_bin_wrap;
        t_fine;
        t_adjust;
        t_snapshot;
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule